// File: doc/BRIEF.md
# Miss-Driven Core Resource Resizing Controller

This controller shrinks parts of an out-of-order core while long-latency data misses are outstanding, when issue activity drops and the capacity goes unused. It watches two conditions: an outstanding second-level cache miss (scenario I), and three or more outstanding first-level data-cache misses (scenario II). Scenario I halves the active issue width and the number of result tags broadcast for wakeup each cycle. Either scenario halves the reorder buffer and the register file.

The issue and wakeup widths come from a two-state machine, WIDE and NARROW. WIDE goes to NARROW when scenario I is seen, and NARROW goes back to WIDE when it clears. Both widths come from this one state, so they always switch together. The two storage structures each have a three-state machine: FULL, DRAIN and HALF. FULL goes to DRAIN on a shrink request, and from then on allocation into the upper half is blocked. DRAIN goes to HALF once that structure's drain-status input reports the upper half empty, and only then is the half powered off. DRAIN and HALF both go back to FULL when neither scenario holds.

Every output comes from a register. It reflects the inputs sampled at the previous rising clock edge.

Top module: `miss_resize_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, issue and wakeup widths are 4, and all allocate and enable outputs are 1.
- R2: The cycle after l2_miss_pending is sampled high, issue_width is 2. The cycle after it is sampled low, issue_width is 4.
- R3: wakeup_width always equals issue_width in the same cycle, and both only take the values 4 and 2.
- R4: Scenario II alone (l1d_miss_count >= 3 with l2_miss_pending low) leaves both widths at 4.
- R5: A shrink request is scenario I or scenario II. From FULL, a shrink request sampled at an edge clears that structure's alloc output after the edge, while its enable output stays 1.
- R6: A structure's enable output drops only after an edge at which the controller was already in DRAIN, the shrink request still held and that structure's empty input was 1. A structure never reaches HALF in a single step from FULL.
- R7: The cycle after an edge at which neither scenario holds, both alloc and enable outputs of each structure are 1, from DRAIN as well as from HALF.
- R8: The reorder buffer and register file machines advance independently, each only on its own empty input.
- R9: An l1d_miss_count of exactly 2 does not request a shrink; a count of exactly 3 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l2_miss_pending | input | 1 | Second-level cache miss outstanding (scenario I) |
| l1d_miss_count | input | 4 | Outstanding first-level data-cache misses |
| rob_hi_empty | input | 1 | Upper reorder buffer half holds no valid entry |
| rf_hi_empty | input | 1 | Upper register file half holds no live register |
| issue_width | output | 3 | Active issue width (4 or 2) |
| wakeup_width | output | 3 | Result tags broadcast per cycle (4 or 2) |
| rob_hi_alloc | output | 1 | Allocation allowed into upper reorder buffer half |
| rob_hi_enable | output | 1 | Upper reorder buffer half powered |
| rf_hi_alloc | output | 1 | Allocation allowed into upper register file half |
| rf_hi_enable | output | 1 | Upper register file half powered |

## Verification
A wrong width state shows one cycle after the input edge, as an issue or wakeup width that differs from the scenario I value sampled there. A wrong storage state shows in the same cycle as a mismatched alloc/enable pair. The worst cases are an enable that drops while the drain input is low, and a structure that stays shrunk after both scenarios have cleared. The bench keeps its own model of each machine and compares every port in every cycle, so a divergence is reported in the first cycle it appears.

// File: rtl/miss_resize_pkg.sv
package miss_resize_pkg;
    typedef enum logic [1:0] {
        ST_FULL  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_HALF  = 2'd2
    } store_state_e;

    typedef enum logic {
        WD_WIDE   = 1'b0,
        WD_NARROW = 1'b1
    } width_state_e;
endpackage

// File: rtl/miss_scenario_decode.sv
module miss_scenario_decode #(
    parameter int CNT_W     = 4,
    parameter int L1_THRESH = 3
) (
    input  logic             l2_pend,
    input  logic [CNT_W-1:0] l1_cnt,
    output logic             scen_one,
    output logic             shrink_req
);
    logic scen_two;

    always_comb begin
        scen_one   = l2_pend;
        scen_two   = (32'(l1_cnt) >= 32'(L1_THRESH));
        shrink_req = scen_one | scen_two;
    end
endmodule

// File: rtl/width_ctrl_fsm.sv
module width_ctrl_fsm
    import miss_resize_pkg::*;
#(
    parameter int FULL_WIDTH = 4,
    localparam int HALF_WIDTH = FULL_WIDTH / 2,
    localparam int WW = $clog2(FULL_WIDTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scen_one,
    output logic [WW-1:0] issue_w,
    output logic [WW-1:0] wake_w
);
    width_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_WIDE:   if (scen_one)  state_d = WD_NARROW;
            WD_NARROW: if (!scen_one) state_d = WD_WIDE;
            default:   state_d = WD_WIDE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_WIDE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            WD_NARROW: begin
                issue_w = WW'(HALF_WIDTH);
                wake_w  = WW'(HALF_WIDTH);
            end
            default: begin
                issue_w = WW'(FULL_WIDTH);
                wake_w  = WW'(FULL_WIDTH);
            end
        endcase
    end

    assert_width_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_w == wake_w) &&
        ((issue_w == WW'(FULL_WIDTH)) || (issue_w == WW'(HALF_WIDTH))));

    assert_narrow_follows_l2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scen_one |=> (issue_w == WW'(HALF_WIDTH)));
endmodule

// File: rtl/half_gate_fsm.sv
module half_gate_fsm
    import miss_resize_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shrink_req,
    input  logic hi_empty,
    output logic hi_alloc,
    output logic hi_enable
);
    store_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FULL:  if (shrink_req) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (!shrink_req)   state_d = ST_FULL;
                else if (hi_empty) state_d = ST_HALF;
            end
            ST_HALF:  if (!shrink_req) state_d = ST_FULL;
            default:  state_d = ST_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FULL;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_DRAIN: begin hi_alloc = 1'b0; hi_enable = 1'b1; end
            ST_HALF:  begin hi_alloc = 1'b0; hi_enable = 1'b0; end
            default:  begin hi_alloc = 1'b1; hi_enable = 1'b1; end
        endcase
    end

    assert_off_needs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_enable) |-> ($past(hi_empty) && $past(shrink_req) && !$past(hi_alloc)));

    assert_no_alloc_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_enable |-> !hi_alloc);

    assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shrink_req |=> (hi_alloc && hi_enable));

    assert_block_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shrink_req |=> !hi_alloc);
endmodule

// File: rtl/miss_resize_ctrl.sv
module miss_resize_ctrl #(
    parameter int FULL_WIDTH = 4,
    parameter int CNT_W      = 4,
    parameter int L1_THRESH  = 3,
    localparam int WW        = $clog2(FULL_WIDTH + 1),
    localparam int NSTORE    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l2_miss_pending,
    input  logic [CNT_W-1:0] l1d_miss_count,
    input  logic             rob_hi_empty,
    input  logic             rf_hi_empty,
    output logic [WW-1:0]    issue_width,
    output logic [WW-1:0]    wakeup_width,
    output logic             rob_hi_alloc,
    output logic             rob_hi_enable,
    output logic             rf_hi_alloc,
    output logic             rf_hi_enable
);
    logic              scen_one;
    logic              shrink_req;
    logic [NSTORE-1:0] empty_v;
    logic [NSTORE-1:0] alloc_v;
    logic [NSTORE-1:0] enable_v;

    miss_scenario_decode #(.CNT_W(CNT_W), .L1_THRESH(L1_THRESH)) u_decode (
        .l2_pend    (l2_miss_pending),
        .l1_cnt     (l1d_miss_count),
        .scen_one   (scen_one),
        .shrink_req (shrink_req)
    );

    width_ctrl_fsm #(.FULL_WIDTH(FULL_WIDTH)) u_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .scen_one (scen_one),
        .issue_w  (issue_width),
        .wake_w   (wakeup_width)
    );

    assign empty_v = {rf_hi_empty, rob_hi_empty};

    for (genvar g = 0; g < NSTORE; g++) begin : g_store
        half_gate_fsm u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .shrink_req (shrink_req),
            .hi_empty   (empty_v[g]),
            .hi_alloc   (alloc_v[g]),
            .hi_enable  (enable_v[g])
        );
    end

    assign rob_hi_alloc  = alloc_v[0];
    assign rob_hi_enable = enable_v[0];
    assign rf_hi_alloc   = alloc_v[1];
    assign rf_hi_enable  = enable_v[1];

    assert_scen2_no_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!l2_miss_pending) |=> (issue_width == WW'(FULL_WIDTH)));
endmodule

// File: tb/miss_resize_ctrl_test.sv
module miss_resize_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l2 = 1'b0;
    logic [3:0] cnt = 4'd0;
    logic       rob_e = 1'b0;
    logic       rf_e = 1'b0;
    logic [2:0] iw, ww;
    logic       rob_a, rob_en, rf_a, rf_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int m_width;
    int m_rob;
    int m_rf;

    always #2 clk = ~clk;

    miss_resize_ctrl uut (
        .clk(clk), .rst_n(rst_n), .l2_miss_pending(l2), .l1d_miss_count(cnt),
        .rob_hi_empty(rob_e), .rf_hi_empty(rf_e),
        .issue_width(iw), .wakeup_width(ww),
        .rob_hi_alloc(rob_a), .rob_hi_enable(rob_en),
        .rf_hi_alloc(rf_a), .rf_hi_enable(rf_en)
    );

    function automatic int next_store(int st, bit req, bit emp);
        if (!req) return 0;
        if (st == 0) return 1;
        if (st == 1 && emp) return 2;
        return st;
    endfunction

    function automatic int exp_width(int narrow);
        return (narrow != 0) ? 2 : 4;
    endfunction

    // model: 0 FULL, 1 DRAIN, 2 HALF
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_width = 0; m_rob = 0; m_rf = 0;
        end else begin
            bit req;
            req = l2 || (cnt >= 4'd3);
            m_width = l2 ? 1 : 0;
            m_rob = next_store(m_rob, req, rob_e);
            m_rf  = next_store(m_rf,  req, rf_e);
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " R2 issue"}, int'(iw), exp_width(m_width));
        chk({tag, " R3 wakeup"}, int'(ww), int'(iw));
        chk({tag, " R5 rob alloc"}, int'(rob_a), (m_rob == 0) ? 1 : 0);
        chk({tag, " R6 rob enable"}, int'(rob_en), (m_rob == 2) ? 0 : 1);
        chk({tag, " R8 rf alloc"}, int'(rf_a), (m_rf == 0) ? 1 : 0);
        chk({tag, " R8 rf enable"}, int'(rf_en), (m_rf == 2) ? 0 : 1);
    endtask

    task automatic step(bit a, logic [3:0] c, bit re, bit fe, string tag);
        l2 = a; cnt = c; rob_e = re; rf_e = fe;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        chk("R1 reset issue", int'(iw), 4);
        chk("R1 reset wakeup", int'(ww), 4);
        chk("R1 reset alloc", int'(rob_a & rf_a), 1);
        chk("R1 reset enable", int'(rob_en & rf_en), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 post reset");

        // R9: count of 2 does not shrink
        step(0, 4'd2, 1, 1, "R9 cnt2");
        step(0, 4'd2, 1, 1, "R9 cnt2 hold");
        chk("R9 cnt2 alloc kept", int'(rob_a), 1);
        // R9/R4: count 3 shrinks storage, widths untouched
        step(0, 4'd3, 0, 0, "R9 cnt3 req");
        chk("R5 alloc blocked", int'(rob_a), 0);
        chk("R4 width full under scen2", int'(iw), 4);
        // R6: drain held non-empty keeps enable
        step(0, 4'd3, 0, 0, "R6 drain busy");
        step(0, 4'd3, 0, 0, "R6 drain busy2");
        chk("R6 enable held while busy", int'(rob_en), 1);
        // R8: rob empties, rf does not
        step(0, 4'd5, 1, 0, "R8 rob empty");
        chk("R8 rob off", int'(rob_en), 0);
        chk("R8 rf still on", int'(rf_en), 1);
        step(0, 4'd5, 1, 1, "R8 rf empty");
        chk("R8 rf off", int'(rf_en), 0);
        // R2: scenario I narrows
        step(1, 4'd0, 1, 1, "R2 l2 on");
        chk("R2 narrow", int'(iw), 2);
        // R7: restore from HALF
        step(0, 4'd0, 0, 0, "R7 clear");
        chk("R7 restore rob", int'(rob_a & rob_en), 1);
        chk("R7 restore rf", int'(rf_a & rf_en), 1);
        chk("R2 wide again", int'(iw), 4);
        // R6: empty already true at request still passes DRAIN
        step(1, 4'd0, 1, 1, "R6 req empty");
        chk("R6 not direct to half", int'(rob_en), 1);
        // R7: restore from DRAIN
        step(0, 4'd1, 1, 1, "R7 from drain");

        for (int i = 0; i < 3000; i++) begin
            bit a;
            logic [3:0] c;
            a = (($urandom % 8) < 3);
            c = 4'($urandom % 6);
            step(a, c, ($urandom % 3) == 0, ($urandom % 3) == 0, "rand");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule